// File: doc/BRIEF.md
# Nine-Bit Multidrop Receive Address Filter

This block sits on the receive side of a nine-bit asynchronous serial link where one master talks to several slaves over a shared line. A small oversampling bit sampler recovers each frame from the serial input. A frame is a start bit, eight data bits sent least significant bit first, a ninth bit and a stop bit. A ninth bit of 1 marks the byte as an address, and a ninth bit of 0 marks it as data.

Each completed frame is passed to a filter. The filter decides whether to latch the byte and raise the sticky receive flag. While filter mode is on, only address frames that select this slave get through. A frame selects the slave when it matches the programmed address under a per-bit compare mask, or when it matches the broadcast pattern derived from the address and the mask.

Firmware programs the address, the mask and the mode bit through a small write port. It typically turns filter mode off after it has been addressed, so that the following data frames also arrive.

Top module: `mdrop_rx_filter`

## Requirements
- R1: Serial frames are a low start bit, then eight data bits least significant first, then the ninth bit, then the stop bit. Each bit lasts OVS clock cycles. An accepted frame's byte appears on rx_data_o and its ninth bit on rx_bit9_o.
- R2: After reset, rx_irq_o, overrun_o, rx_bit9_o and rx_data_o are all 0. The slave address, the compare mask and filter mode are also 0, so every frame with a good stop bit is accepted.
- R3: While filter mode is off, every frame with a high stop bit is accepted, whatever its ninth bit. Accepting a frame sets rx_irq_o and latches the byte and the ninth bit.
- R4: While filter mode is on, a frame with ninth bit 1 is accepted when ((byte ^ address) & mask) == 0. Mask bits of 0 are don't-care.
- R5: While filter mode is on, a frame with ninth bit 1 is also accepted when the byte has a 1 in every position where (address | mask) is 1. As a result, a received 0xFF is accepted by any slave.
- R6: While filter mode is on, a frame with ninth bit 0 is discarded, and so is an address frame that meets neither R4 nor R5. A discarded frame leaves rx_irq_o, rx_data_o and rx_bit9_o unchanged.
- R7: A frame whose stop bit samples low is discarded in any mode, with no change to the flag, the data or the ninth bit.
- R8: rx_irq_o stays set until a clear write. A clear write is wr_sel_i = 3 with wr_data_i[0] = 1, and wr_data_i[1] = 1 in the same write clears overrun_o.
- R9: A frame accepted while rx_irq_o is still set overwrites rx_data_o and rx_bit9_o and sets overrun_o.
- R10: The register write encoding on wr_sel_i is: 0 writes the slave address, 1 writes the compare mask, and 2 writes filter mode from wr_data_i[0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial receive line, idle high |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 address, 1 mask, 2 mode, 3 clear |
| wr_data_i | input | 8 | Register write data |
| rx_irq_o | output | 1 | Sticky receive flag |
| overrun_o | output | 1 | Sticky overrun status |
| rx_data_o | output | 8 | Last accepted byte |
| rx_bit9_o | output | 1 | Ninth bit of the last accepted frame |

## Verification
The assertions check four things on every cycle:
- that the flag only rises one cycle after a frame strobe;
- that data frames under filter mode and frames with a low stop bit leave the flag, the data and the ninth bit untouched;
- that every good frame in accept-all mode raises the flag;
- that overrun only rises while the flag is already set.

Only the bench's scenarios can show the rest. This covers whether the unicast and broadcast comparisons pick the right frames for a given address and mask, including the worked mask patterns. It also covers whether the serial timing recovers the right byte, and whether clear writes and the sticky overrun behave correctly across sequences of frames.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
  localparam int unsigned DW = 8;

  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_MODE  = 2'd2,
    SEL_CLEAR = 2'd3
  } wr_sel_e;

  typedef struct packed {
    logic [DW-1:0] data;
    logic          bit9;
    logic          stop_ok;
  } frame_t;
endpackage

// File: rtl/mdrop_bit_sampler.sv
module mdrop_bit_sampler
  import mdrop_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   rxd_i,
  output logic   frm_valid_o,
  output frame_t frm_o
);
  localparam int unsigned CW    = (OVS > 2) ? $clog2(OVS) : 1;
  localparam int unsigned NBITS = DW + 2;   // data, ninth, stop
  localparam int unsigned IW    = $clog2(NBITS);

  typedef enum logic [1:0] {S_IDLE, S_START, S_SHIFT} st_e;

  st_e           st_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic [DW:0]   sh_q;
  logic [1:0]    sync_q;
  logic          prev_q;
  logic          rx_s;

  assign rx_s = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      prev_q <= rx_s;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      cnt_q       <= '0;
      idx_q       <= '0;
      sh_q        <= '0;
      frm_valid_o <= 1'b0;
      frm_o       <= '0;
    end else begin
      frm_valid_o <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (prev_q && !rx_s) begin
            st_q  <= S_START;
            cnt_q <= CW'(OVS/2 - 1);
          end
        end
        S_START: begin
          if (cnt_q == '0) begin
            if (!rx_s) begin
              st_q  <= S_SHIFT;
              cnt_q <= CW'(OVS - 1);
              idx_q <= '0;
            end else begin
              st_q <= S_IDLE;   // glitch, not a start bit
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_SHIFT: begin
          if (cnt_q == '0) begin
            cnt_q <= CW'(OVS - 1);
            if (idx_q == IW'(NBITS - 1)) begin
              frm_valid_o   <= 1'b1;
              frm_o.data    <= sh_q[DW-1:0];
              frm_o.bit9    <= sh_q[DW];
              frm_o.stop_ok <= rx_s;
              st_q          <= S_IDLE;
            end else begin
              sh_q  <= {rx_s, sh_q[DW:1]};
              idx_q <= idx_q + 1'b1;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdrop_addr_match.sv
module mdrop_addr_match #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] rx_i,
  input  logic [W-1:0] addr_i,
  input  logic [W-1:0] mask_i,
  output logic         uni_hit_o,
  output logic         bc_hit_o
);
  logic [W-1:0] bc_care;
  assign bc_care = addr_i | mask_i;

  logic [W-1:0] uni_miss, bc_miss;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign uni_miss[i] = mask_i[i]  & (rx_i[i] ^ addr_i[i]);
    assign bc_miss[i]  = bc_care[i] & ~rx_i[i];
  end

  assign uni_hit_o = ~|uni_miss;
  assign bc_hit_o  = ~|bc_miss;
endmodule

// File: rtl/mdrop_rx_filter.sv
module mdrop_rx_filter
  import mdrop_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rxd_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          rx_irq_o,
  output logic          overrun_o,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_bit9_o
);
  logic          frm_valid;
  frame_t        frm;
  logic [DW-1:0] addr_q, mask_q;
  logic          filt_en_q;
  logic          uni_hit, bc_hit, accept;
  logic          wr_clr_flag, wr_clr_ovr;

  mdrop_bit_sampler #(.OVS(OVS)) u_sampler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rxd_i      (rxd_i),
    .frm_valid_o(frm_valid),
    .frm_o      (frm)
  );

  mdrop_addr_match #(.W(DW)) u_match (
    .rx_i     (frm.data),
    .addr_i   (addr_q),
    .mask_i   (mask_q),
    .uni_hit_o(uni_hit),
    .bc_hit_o (bc_hit)
  );

  assign accept = frm_valid && frm.stop_ok &&
                  (!filt_en_q || (frm.bit9 && (uni_hit || bc_hit)));

  assign wr_clr_flag = wr_en_i && (wr_sel_i == SEL_CLEAR) && wr_data_i[0];
  assign wr_clr_ovr  = wr_en_i && (wr_sel_i == SEL_CLEAR) && wr_data_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q    <= '0;
      mask_q    <= '0;
      filt_en_q <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_sel_i)
        SEL_ADDR: addr_q    <= wr_data_i;
        SEL_MASK: mask_q    <= wr_data_i;
        SEL_MODE: filt_en_q <= wr_data_i[0];
        default: ;
      endcase
    end
  end

  // a frame landing in the same cycle as a clear wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_irq_o  <= 1'b0;
      overrun_o <= 1'b0;
      rx_data_o <= '0;
      rx_bit9_o <= 1'b0;
    end else begin
      if (accept) begin
        rx_data_o <= frm.data;
        rx_bit9_o <= frm.bit9;
        rx_irq_o  <= 1'b1;
        if (rx_irq_o) overrun_o <= 1'b1;
        else if (wr_clr_ovr) overrun_o <= 1'b0;
      end else begin
        if (wr_clr_flag) rx_irq_o  <= 1'b0;
        if (wr_clr_ovr)  overrun_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mdrop_rx_filter_chk.sv
module mdrop_rx_filter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frm_valid,
  input logic       frm_bit9,
  input logic       frm_stop_ok,
  input logic       filt_en_q,
  input logic       rx_irq_o,
  input logic       overrun_o,
  input logic [7:0] rx_data_o,
  input logic       rx_bit9_o
);
  // R3
  flag_rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_irq_o) |-> $past(frm_valid));

  // R3
  accept_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid && frm_stop_ok && !filt_en_q |=> rx_irq_o && rx_bit9_o == $past(frm_bit9));

  // R6
  data_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid && filt_en_q && !frm_bit9 |=> $stable(rx_data_o) && $stable(rx_bit9_o) && !$rose(rx_irq_o));

  // R7
  framing_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid && !frm_stop_ok |=> $stable(rx_data_o) && $stable(rx_bit9_o) && !$rose(rx_irq_o));

  // R9
  overrun_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(rx_irq_o) && $past(frm_valid));

  // R1
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_valid |=> $stable(rx_data_o) && $stable(rx_bit9_o));
endmodule

bind mdrop_rx_filter mdrop_rx_filter_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .frm_valid  (frm_valid),
  .frm_bit9   (frm.bit9),
  .frm_stop_ok(frm.stop_ok),
  .filt_en_q  (filt_en_q),
  .rx_irq_o   (rx_irq_o),
  .overrun_o  (overrun_o),
  .rx_data_o  (rx_data_o),
  .rx_bit9_o  (rx_bit9_o)
);

// File: tb/mdrop_rx_filter_bench.sv
module mdrop_rx_filter_bench;
  localparam int unsigned OVS = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rxd = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       rx_irq, overrun, rx_bit9;
  logic [7:0] rx_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] m_addr = 8'h00, m_mask = 8'h00;
  logic       m_mode = 1'b0;
  logic [7:0] e_data = 8'h00;
  logic       e_bit9 = 1'b0, e_irq = 1'b0, e_ovr = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  mdrop_rx_filter #(.OVS(OVS)) u_mdrop_rx_filter (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .rxd_i    (rxd),
    .wr_en_i  (wr_en),
    .wr_sel_i (wr_sel),
    .wr_data_i(wr_data),
    .rx_irq_o (rx_irq),
    .overrun_o(overrun),
    .rx_data_o(rx_data),
    .rx_bit9_o(rx_bit9)
  );

  function automatic bit f_accept(input logic [7:0] b, input logic b9, input logic stop);
    logic uni, bc;
    uni = ((b ^ m_addr) & m_mask) == 8'h00;
    bc  = ((b ^ 8'hFF) & (m_addr | m_mask)) == 8'h00;
    return stop && (!m_mode || (b9 && (uni || bc)));
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (s)
      2'd0: m_addr = d;
      2'd1: m_mask = d;
      2'd2: m_mode = d[0];
      default: begin
        if (d[0]) e_irq = 1'b0;
        if (d[1]) e_ovr = 1'b0;
      end
    endcase
  endtask

  task automatic send(input logic [7:0] b, input logic b9, input logic stop);
    logic [10:0] bits;
    bits = {stop, b9, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      rxd = bits[i];
      repeat (OVS - 1) @(negedge clk);
    end
    @(negedge clk);
    rxd = 1'b1;
    repeat (2 * OVS) @(negedge clk);
    if (f_accept(b, b9, stop)) begin
      if (e_irq) e_ovr = 1'b1;
      e_irq  = 1'b1;
      e_data = b;
      e_bit9 = b9;
    end
  endtask

  task automatic expect_all(input string tag);
    check({tag, " irq"},  rx_irq,  e_irq);
    check({tag, " data"}, rx_data, e_data);
    check({tag, " bit9"}, rx_bit9, e_bit9);
    check({tag, " ovr"},  overrun, e_ovr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R2 reset state
    expect_all("R2 reset");
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    expect_all("R2 after reset");

    // R2/R3 accept-all from reset, data and address frames
    send(8'hA5, 1'b0, 1'b1); expect_all("R3 data frame mode off");
    wr(2'd3, 8'h03);         expect_all("R8 clear");
    send(8'h3C, 1'b1, 1'b1); expect_all("R1 R3 addr frame mode off");
    // R9 overrun on second frame without clear
    send(8'h5A, 1'b0, 1'b1); expect_all("R9 overrun");
    wr(2'd3, 8'h01);         expect_all("R8 flag clear only");
    wr(2'd3, 8'h02);         expect_all("R8 overrun clear");

    // R7 framing error while accept-all
    send(8'h77, 1'b1, 1'b0); expect_all("R7 stop low mode off");

    // R10 worked mask patterns, R4
    wr(2'd0, 8'h35); wr(2'd1, 8'h0F); wr(2'd2, 8'h01);
    send(8'h45, 1'b1, 1'b1); expect_all("R4 mask 0F hit");
    wr(2'd3, 8'h03);
    send(8'h46, 1'b1, 1'b1); expect_all("R6 mask 0F miss");
    wr(2'd1, 8'hF3);
    send(8'h39, 1'b1, 1'b1); expect_all("R4 mask F3 hit");
    wr(2'd3, 8'h03);
    send(8'h35, 1'b0, 1'b1); expect_all("R6 data frame filtered");
    wr(2'd1, 8'hC0);
    send(8'h3F, 1'b1, 1'b1); expect_all("R4 mask C0 hit");
    wr(2'd3, 8'h03);
    send(8'h7F, 1'b1, 1'b1); expect_all("R6 mask C0 miss");
    // R5 broadcast
    send(8'hFF, 1'b1, 1'b1); expect_all("R5 broadcast FF");
    wr(2'd3, 8'h03);
    send(8'hF5, 1'b1, 1'b1); expect_all("R5 broadcast F5");
    wr(2'd3, 8'h03);
    send(8'h35, 1'b1, 1'b0); expect_all("R7 stop low filtered");

    // random mix
    for (int it = 0; it < 260; it++) begin
      logic [7:0] b;
      logic b9, stop;
      int r;
      r = $urandom_range(0, 19);
      if (r == 0) wr(2'd0, 8'($urandom()));
      else if (r == 1) wr(2'd1, 8'($urandom()));
      else if (r == 2) wr(2'd2, 8'($urandom()));
      b = 8'($urandom());
      case ($urandom_range(0, 3))
        0: b = (m_addr & m_mask) | (b & ~m_mask);
        1: b = b | m_addr | m_mask;
        default: ;
      endcase
      b9   = ($urandom_range(0, 3) != 0);
      stop = ($urandom_range(0, 7) != 0);
      send(b, b9, stop);
      expect_all("R4 R5 R6 R7 R9 random");
      if ($urandom_range(0, 2) != 0) begin
        wr(2'd3, 8'($urandom_range(0, 3)));
        expect_all("R8 random clear");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule